// File: doc/BRIEF.md
# Two-Player Dice Game Controller

This block runs a turn-based dice game between two players. A free-running pseudo-random generator supplies a die face for every roll request. The face is added to the score of the player whose turn it is, and the turn then passes to the other player. When one player's score reaches the target, the game ends. That player is flagged as the winner and stays flagged until the next reset.

The roll request is a single-cycle pulse, which is assumed to be already debounced. The die face, both scores, the player to move, the game-over flag and the winner are all presented as plain registered outputs that can drive a display.

Top module: `dice_game_top`

## Requirements
- R1: The random source is an 8-bit Fibonacci shift register that shifts toward the MSB and takes its new bit 0 from the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). It loads the seed 8'hA5 during reset, advances on every clock edge after reset whether or not a roll is pending, and never holds zero.
- R2: The die face comes from bits [2:0] of the random register. A sample of 0 or 7 is rejected, and the next cycle's value is tried instead, until a value from 1 to 6 is found. A face of 0 appears only before the first roll after reset.
- R3: A roll pulse is seen at clock edge E1 while the game waits for a roll. At E2, the following edge, the register value is sampled. On the first edge with an accepted sample, the die face output and the score are updated.
- R4: Each roll adds the die face to the score of the player to move. The other player's score is unchanged.
- R5: The turn output is 0 for the first player and 1 for the second. After a roll that does not end the game, the turn passes to the other player.
- R6: When a score reaches or exceeds TARGET (default 30), the game-over flag goes to 1 and the winner output shows that player (0 or 1). After that, every roll pulse is ignored: scores, die face, turn and winner all hold until reset.
- R7: Reset, which is synchronous and active high, clears both scores, the die face, the game-over flag and the winner to 0. It also gives the first move to player 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| roll_i | input | 1 | Single-cycle roll request |
| die_o | output | 3 | Last die face (0 after reset, then 1 to 6) |
| score_a_o | output | SCORE_W | Score of player 0 |
| score_b_o | output | SCORE_W | Score of player 1 |
| turn_o | output | 1 | Player to move (0 or 1) |
| over_o | output | 1 | Game over, a winner exists |
| winner_o | output | 1 | Identity of the winner |

## Verification
The hardest situation to reach from the ports is a rejected sample. Whether a roll waits extra cycles depends entirely on the generator phase at the moment the roll is requested. To cover it, the bench keeps its own model of the generator from the seed, and it predicts the exact face by stepping that model cycle by cycle until an accepted value appears. Rolls are issued back to back, so the generator phase drifts from roll to roll. A full game is played to the target, so over many rolls both immediate acceptance and multi-cycle rejection runs occur. The game-over hold and a reset in the middle of a game are then exercised with further roll pulses.

// File: rtl/dice_pkg.sv
package dice_pkg;
    localparam int LFSR_W = 8;
    localparam logic [LFSR_W-1:0] TAP_MASK = 8'hB8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;
    localparam int FACE_W = 3;
    localparam int FACE_MAX = 6;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_DRAW = 2'd1,
        ST_OVER = 2'd2
    } game_state_e;
endpackage

// File: rtl/dice_lfsr.sv
module dice_lfsr
    import dice_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] value_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;
    logic              fb;

    always_comb begin
        fb     = ^(lfsr_q & TAP_MASK);
        lfsr_d = {lfsr_q[LFSR_W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= LFSR_SEED;
        else     lfsr_q <= lfsr_d;
    end

    assign value_o = lfsr_q;
endmodule

// File: rtl/dice_face_filter.sv
module dice_face_filter
    import dice_pkg::*;
(
    input  logic [FACE_W-1:0] raw_i,
    output logic              ok_o,
    output logic [FACE_W-1:0] face_o
);
    always_comb begin
        ok_o   = (raw_i != '0) && (int'(raw_i) <= FACE_MAX);
        face_o = raw_i;
    end
endmodule

// File: rtl/dice_turn_fsm.sv
module dice_turn_fsm
    import dice_pkg::*;
#(
    parameter int TARGET  = 30,
    parameter int SCORE_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               roll_i,
    input  logic               face_ok_i,
    input  logic [FACE_W-1:0]  face_i,
    output logic [FACE_W-1:0]  die_o,
    output logic [SCORE_W-1:0] score_a_o,
    output logic [SCORE_W-1:0] score_b_o,
    output logic               turn_o,
    output logic               over_o,
    output logic               winner_o
);
    typedef struct packed {
        game_state_e              state;
        logic [FACE_W-1:0]        die;
        logic [1:0][SCORE_W-1:0]  score;
        logic                     turn;
        logic                     winner;
    } fsm_t;

    fsm_t r_q, r_d;
    logic [SCORE_W-1:0] sum;

    always_comb begin
        r_d = r_q;
        sum = r_q.score[r_q.turn] + SCORE_W'(face_i);
        unique case (r_q.state)
            ST_WAIT: begin
                if (roll_i) r_d.state = ST_DRAW;
            end
            ST_DRAW: begin
                if (face_ok_i) begin
                    r_d.die              = face_i;
                    r_d.score[r_q.turn]  = sum;
                    if (sum >= SCORE_W'(TARGET)) begin
                        r_d.state  = ST_OVER;
                        r_d.winner = r_q.turn;
                    end else begin
                        r_d.state = ST_WAIT;
                        r_d.turn  = ~r_q.turn;
                    end
                end
            end
            ST_OVER: ;
            default: r_d.state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_WAIT, die: '0, score: '0, turn: 1'b0, winner: 1'b0};
        else     r_q <= r_d;
    end

    assign die_o     = r_q.die;
    assign score_a_o = r_q.score[0];
    assign score_b_o = r_q.score[1];
    assign turn_o    = r_q.turn;
    assign over_o    = (r_q.state == ST_OVER);
    assign winner_o  = r_q.winner;
endmodule

// File: rtl/dice_game_top.sv
module dice_game_top
    import dice_pkg::*;
#(
    parameter int TARGET  = 30,
    parameter int SCORE_W = $clog2(TARGET + FACE_MAX)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               roll_i,
    output logic [2:0]         die_o,
    output logic [SCORE_W-1:0] score_a_o,
    output logic [SCORE_W-1:0] score_b_o,
    output logic               turn_o,
    output logic               over_o,
    output logic               winner_o
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              face_ok;
    logic [FACE_W-1:0] face;

    dice_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .value_o (lfsr_q)
    );

    dice_face_filter u_filter (
        .raw_i  (lfsr_q[FACE_W-1:0]),
        .ok_o   (face_ok),
        .face_o (face)
    );

    dice_turn_fsm #(.TARGET(TARGET), .SCORE_W(SCORE_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .roll_i    (roll_i),
        .face_ok_i (face_ok),
        .face_i    (face),
        .die_o     (die_o),
        .score_a_o (score_a_o),
        .score_b_o (score_b_o),
        .turn_o    (turn_o),
        .over_o    (over_o),
        .winner_o  (winner_o)
    );
endmodule

// File: rtl/dice_game_chk.sv
module dice_game_chk #(
    parameter int SCORE_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         lfsr,
    input logic [2:0]         die,
    input logic [SCORE_W-1:0] sa,
    input logic [SCORE_W-1:0] sb,
    input logic               turn,
    input logic               over
);
    p_lfsr_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
        lfsr != 8'h00);

    p_face_range_r2: assert property (@(posedge clk) disable iff (rst)
        (die <= 3'd6) && (die != 3'd0 || (sa == '0 && sb == '0)));

    p_single_mover_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !((sa != $past(sa)) && (sb != $past(sb))));

    p_score_monotone_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sa >= $past(sa)) && (sb >= $past(sb)));

    p_turn_passes_r5: assert property (@(posedge clk) disable iff (rst)
        ((sa != $past(sa)) && !over) |-> turn);

    p_over_hold_r6: assert property (@(posedge clk) disable iff (rst)
        over |=> over && $stable(sa) && $stable(sb) && $stable(die) && $stable(turn));
endmodule

bind dice_game_top dice_game_chk #(.SCORE_W(SCORE_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .lfsr (lfsr_q),
    .die  (die_o),
    .sa   (score_a_o),
    .sb   (score_b_o),
    .turn (turn_o),
    .over (over_o)
);

// File: tb/dice_game_top_tb_top.sv
`timescale 1ns/1ps
module dice_game_top_tb_top;
    localparam int TARGET  = 30;
    localparam int SCORE_W = $clog2(TARGET + 6);

    typedef struct {
        logic [2:0]         die;
        logic [SCORE_W-1:0] sa;
        logic [SCORE_W-1:0] sb;
        logic               turn;
        logic               over;
        logic               winner;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic roll = 1'b0;
    logic [2:0]         die;
    logic [SCORE_W-1:0] sa, sb;
    logic               turn, over, winner;

    int n_tests = 0;
    int n_fail  = 0;
    int n_reject = 0;
    bit done = 1'b0;

    item_t q[$];

    // expected game state
    logic [2:0]         e_die;
    logic [SCORE_W-1:0] e_sa, e_sb;
    logic               e_turn, e_over, e_win;

    logic [7:0] m_lfsr;

    always #10 clk = ~clk;

    dice_game_top #(.TARGET(TARGET)) dut_i (
        .clk(clk), .rst(rst), .roll_i(roll),
        .die_o(die), .score_a_o(sa), .score_b_o(sb),
        .turn_o(turn), .over_o(over), .winner_o(winner)
    );

    // R1: independent model of the random source
    always @(posedge clk) begin
        if (rst) m_lfsr <= 8'hA5;
        else     m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        e_die = 0; e_sa = 0; e_sb = 0; e_turn = 0; e_over = 0; e_win = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    // driver: one roll, predicts the result and queues it
    task automatic roll_once();
        item_t it;
        logic [SCORE_W-1:0] s;
        @(negedge clk);
        roll = 1'b1;
        @(negedge clk);
        roll = 1'b0;
        if (e_over) return;
        // m_lfsr now holds the value sampled at the next edge (R3)
        for (int k = 0; k < 64; k++) begin
            if (m_lfsr[2:0] != 3'd0 && m_lfsr[2:0] != 3'd7) break;
            n_reject++;
            @(negedge clk);
        end
        e_die = m_lfsr[2:0];
        s = (e_turn ? e_sb : e_sa) + SCORE_W'(e_die);
        if (e_turn) e_sb = s; else e_sa = s;
        if (s >= SCORE_W'(TARGET)) begin
            e_over = 1'b1;
            e_win  = e_turn;
        end else begin
            e_turn = ~e_turn;
        end
        it.die = e_die; it.sa = e_sa; it.sb = e_sb;
        it.turn = e_turn; it.over = e_over; it.winner = e_win;
        q.push_back(it);
    endtask

    // monitor: any score change pops and compares one queued item
    logic [SCORE_W-1:0] p_sa = '0, p_sb = '0;
    always @(negedge clk) begin
        if (rst) begin
            p_sa <= '0; p_sb <= '0;
        end else begin
            if (sa != p_sa || sb != p_sb) begin
                if (q.size() == 0) begin
                    check("R6", "unexpected score change", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check("R2", "die face", die, it.die);
                    check("R4", "score of player 0", sa, it.sa);
                    check("R4", "score of player 1", sb, it.sb);
                    check("R5", "turn", turn, it.turn);
                    check("R6", "game over", over, it.over);
                    if (it.over) check("R6", "winner", winner, it.winner);
                end
            end
            p_sa <= sa; p_sb <= sb;
        end
    end

    task automatic check_reset_state(input string tag);
        check("R7", {tag, " score0"}, sa, 0);
        check("R7", {tag, " score1"}, sb, 0);
        check("R7", {tag, " die"}, die, 0);
        check("R7", {tag, " turn"}, turn, 0);
        check("R7", {tag, " over"}, over, 0);
        check("R7", {tag, " winner"}, winner, 0);
    endtask

    initial begin
        clear_model();
        do_reset();
        @(negedge clk);
        check_reset_state("after reset");

        // R1: generator advances while idle; wait some cycles without rolling
        repeat (7) @(negedge clk);
        check("R1", "idle keeps game state", sa + sb, 0);

        // R3/R4/R5: full game to the target
        for (int r = 0; r < 60 && !e_over; r++) roll_once();
        repeat (3) @(negedge clk);
        check("R6", "game finished", over, 1);
        check("R6", "queue drained", q.size(), 0);
        check("R6", "winner score at target", ((winner ? sb : sa) >= TARGET) ? 1 : 0, 1);

        // R6: rolls after game over are ignored
        begin
            logic [SCORE_W-1:0] ha, hb;
            logic [2:0] hd;
            logic ht, hw;
            ha = sa; hb = sb; hd = die; ht = turn; hw = winner;
            for (int r = 0; r < 4; r++) roll_once();
            repeat (4) @(negedge clk);
            check("R6", "score0 held", sa, ha);
            check("R6", "score1 held", sb, hb);
            check("R6", "die held", die, hd);
            check("R6", "turn held", turn, ht);
            check("R6", "winner held", winner, hw);
            check("R6", "over held", over, 1);
        end

        // R7: reset after game over starts a new game
        do_reset();
        @(negedge clk);
        check_reset_state("new game");

        // a few rolls then reset in the middle of a game
        for (int r = 0; r < 5; r++) roll_once();
        repeat (3) @(negedge clk);
        check("R4", "mid-game scores nonzero", (sa + sb > 0) ? 1 : 0, 1);
        do_reset();
        @(negedge clk);
        check_reset_state("mid-game reset");

        // R5: first roll after reset belongs to player 0
        roll_once();
        repeat (3) @(negedge clk);
        check("R5", "first roll to player 0", (sa > 0 && sb == 0) ? 1 : 0, 1);

        $display("[TB] rejected samples seen: %0d", n_reject);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(20ns * 150000);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule